// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port. Software writes either register through a single-cycle write strobe with per-byte enables, and both registers are always visible on read ports. Physical slot events arrive as one-cycle pulses: a card being inserted, a card being pulled, and the attention button being pressed. A static strap tells the block whether the slot is populated when reset is applied.

The block raises an interrupt when the notify level becomes true. The notify level is true when the master hot-plug interrupt enable is set and at least one of three events (button pressed, presence changed, command completed) is pending in status with its own enable set in control. With message signalling on, a rise of that level produces a one-cycle message request that carries a 5-bit vector. With message signalling off, a level interrupt follows the notify level. Every control write counts as one command and posts a command-completed event. A control write that turns the power controller off while the power indicator is off and a card is present requests a detach of the downstream devices.

Top module: `hp_slot_ctrl`

## Requirements
- R1: While reset is asserted, control resets to all enables 0, attention indicator off (bits 7:6 = 11), and power controller (bit 10, 1 = off) and power indicator (bits 9:8, 01 = on, 11 = off) set from the populated strap: 16'h01C0 if populated, 16'h07C0 if empty. Status resets to presence (bit 6) = strap with every other bit 0. All outputs are low.
- R2: The notify level is control bit 5 AND the OR, over bit positions 0, 3 and 4, of status AND control. With message signalling off, irq_o equals the notify level one cycle after the edge that changed the state, so a status write that clears the last pending enabled event drops irq_o.
- R3: With message signalling on, msg_req_o pulses for exactly one cycle after each edge on which the notify level goes from 0 to 1, and msg_vec_o then carries the vector input. A falling level sends no message, and irq_o stays low.
- R4: An event whose status bit is already set causes no new message.
- R5: An event that arrives while bit 5 is clear is delivered as a message when a later control write sets bit 5.
- R6: Status bits 0, 3 and 4 are write-1-to-clear, each only when its byte enable is set. Presence (bit 6) and interlock (bit 7) are not changed by status writes.
- R7: Every control write sets status bit 4 (command completed) on the same edge.
- R8: Control bits 0 and 3 to 10 are writable under their byte enables. The other bits read 0. Writing 1 to bit 11 with byte 1 enabled toggles status bit 7, and bit 11 still reads 0.
- R9: A control write whose merged value has bit 10 = 1 and bits 9:8 = 11 while presence is set pulses detach_o for one cycle, clears presence and sets status bit 3.
- R10: An accepted insertion sets presence and status bits 3 and 0. Removal of a present card clears presence and sets bit 3. A button press sets bit 0. Removal wins over a same-cycle insertion.
- R11: An insertion while status bit 7 is set pulses busy_err_o for one cycle and leaves presence and the event bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| populated_i | input | 1 | Strap: slot holds a card at reset |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_sel_i | input | 1 | 0 selects control, 1 selects status |
| wr_be_i | input | 2 | Byte enables |
| wr_data_i | input | 16 | Write data |
| card_insert_i | input | 1 | Card insertion pulse |
| card_remove_i | input | 1 | Card removal pulse |
| button_i | input | 1 | Attention button pulse |
| msg_en_i | input | 1 | Message signalling enabled |
| msg_vec_i | input | 5 | Interrupt message number |
| ctrl_o | output | 16 | Slot control read value |
| status_o | output | 16 | Slot status read value |
| irq_o | output | 1 | Level interrupt |
| msg_req_o | output | 1 | One-cycle message request |
| msg_vec_o | output | 5 | Vector carried by the message |
| detach_o | output | 1 | Detach request pulse |
| busy_err_o | output | 1 | Insertion rejected, slot locked |

## Verification
The bench aims at the edge-based notification. It re-presses a button whose bit is still pending, where a level-sensitive design would send a second message. It presses the button while the master enable is off and then enables it, where a design that drops masked events would stay silent. It toggles the interlock twice and attempts an insertion in between, so a design that stores the write-only bit or accepts a locked insertion shows a wrong control read or wrong presence. It also repeats the power-off write on an empty slot, where a design that ignores presence would issue a second detach. Status writes with the wrong byte enables and with presence and lock bits set check that the write-1-to-clear mask does not leak.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W  = 16;
  localparam int NBYTES = REG_W / 8;

  // control fields
  localparam int C_ABP_EN   = 0;
  localparam int C_PDC_EN   = 3;
  localparam int C_CC_EN    = 4;
  localparam int C_HP_EN    = 5;
  localparam int C_AI_LO    = 6;
  localparam int C_PI_LO    = 8;
  localparam int C_PWR_OFF  = 10;
  localparam int C_LOCK_TGL = 11;

  // status fields
  localparam int S_ABP  = 0;
  localparam int S_PDC  = 3;
  localparam int S_CC   = 4;
  localparam int S_PRES = 6;
  localparam int S_LOCK = 7;

  localparam logic [REG_W-1:0] CTRL_WMASK = 16'h07F9;
  localparam logic [REG_W-1:0] EVT_MASK   = 16'h0019;

  typedef enum logic [1:0] {
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_e;
endpackage

// File: rtl/hp_slot_ctrl_reg.sv
module hp_slot_ctrl_reg
  import hp_slot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              populated_i,
  input  logic              wr_i,
  input  logic [NBYTES-1:0] be_i,
  input  logic [REG_W-1:0]  data_i,
  input  logic              present_i,
  output logic [REG_W-1:0]  ctrl_q_o,
  output logic [REG_W-1:0]  ctrl_d_o,
  output logic              lock_tgl_o,
  output logic              detach_o
);
  localparam int LOCK_BYTE = C_LOCK_TGL / 8;

  logic [REG_W-1:0] ctrl_q, merged, rst_val;

  always_comb begin
    rst_val = '0;
    rst_val[C_AI_LO +: 2] = IND_OFF;
    rst_val[C_PI_LO +: 2] = populated_i ? IND_ON : IND_OFF;
    rst_val[C_PWR_OFF]    = ~populated_i;
  end

  always_comb begin
    merged = ctrl_q;
    for (int b = 0; b < NBYTES; b++) begin
      if (be_i[b]) merged[b*8 +: 8] = data_i[b*8 +: 8] & CTRL_WMASK[b*8 +: 8];
    end
  end

  assign ctrl_d_o   = wr_i ? merged : ctrl_q;
  assign lock_tgl_o = wr_i & be_i[LOCK_BYTE] & data_i[C_LOCK_TGL];
  // safe-removal command: power off with indicator dark
  assign detach_o   = wr_i & present_i & merged[C_PWR_OFF] &
                      (merged[C_PI_LO +: 2] == IND_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= rst_val;
    else         ctrl_q <= ctrl_d_o;
  end

  assign ctrl_q_o = ctrl_q;
endmodule

// File: rtl/hp_slot_sts_reg.sv
module hp_slot_sts_reg
  import hp_slot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              populated_i,
  input  logic              wr_i,
  input  logic [NBYTES-1:0] be_i,
  input  logic [REG_W-1:0]  data_i,
  input  logic              cmd_i,
  input  logic              lock_tgl_i,
  input  logic              detach_i,
  input  logic              insert_i,
  input  logic              remove_i,
  input  logic              button_i,
  output logic [REG_W-1:0]  sts_q_o,
  output logic [REG_W-1:0]  sts_d_o,
  output logic              busy_o
);
  logic [REG_W-1:0] sts_q, clr, d;
  logic ins_ok, rem_ok;

  always_comb begin
    clr = '0;
    if (wr_i) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (be_i[b]) clr[b*8 +: 8] = data_i[b*8 +: 8] & EVT_MASK[b*8 +: 8];
      end
    end
  end

  assign ins_ok = insert_i & ~sts_q[S_LOCK];
  assign rem_ok = remove_i & sts_q[S_PRES];
  assign busy_o = insert_i & sts_q[S_LOCK];

  always_comb begin
    d = sts_q & ~clr;
    if (cmd_i)      d[S_CC]   = 1'b1;
    if (lock_tgl_i) d[S_LOCK] = ~sts_q[S_LOCK];
    if (ins_ok) begin
      d[S_PRES] = 1'b1;
      d[S_PDC]  = 1'b1;
      d[S_ABP]  = 1'b1;
    end
    if (rem_ok || detach_i) begin
      d[S_PRES] = 1'b0;
      d[S_PDC]  = 1'b1;
    end
    if (button_i) d[S_ABP] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q         <= '0;
      sts_q[S_PRES] <= populated_i;
    end else begin
      sts_q <= d;
    end
  end

  assign sts_q_o = sts_q;
  assign sts_d_o = d;
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] ctrl_d_i,
  input  logic [REG_W-1:0] sts_d_i,
  input  logic             msg_en_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             irq_o,
  output logic             msg_o,
  output logic [VEC_W-1:0] vec_o
);
  logic lvl_d, lvl_q, msg_q;
  logic [VEC_W-1:0] vec_q;

  assign lvl_d = ctrl_d_i[C_HP_EN] & (|(sts_d_i & ctrl_d_i & EVT_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      msg_q <= 1'b0;
      vec_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      msg_q <= msg_en_i & lvl_d & ~lvl_q;
      if (msg_en_i & lvl_d & ~lvl_q) vec_q <= vec_i;
    end
  end

  assign irq_o = lvl_q & ~msg_en_i;
  assign msg_o = msg_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              populated_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [NBYTES-1:0] wr_be_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              card_insert_i,
  input  logic              card_remove_i,
  input  logic              button_i,
  input  logic              msg_en_i,
  input  logic [VEC_W-1:0]  msg_vec_i,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [REG_W-1:0]  status_o,
  output logic              irq_o,
  output logic              msg_req_o,
  output logic [VEC_W-1:0]  msg_vec_o,
  output logic              detach_o,
  output logic              busy_err_o
);
  logic ctrl_wr, sts_wr, lock_tgl, detach, busy;
  logic [REG_W-1:0] ctrl_q, ctrl_d, sts_q, sts_d;
  logic detach_q, busy_q;

  assign ctrl_wr = wr_en_i & ~wr_sel_i;
  assign sts_wr  = wr_en_i &  wr_sel_i;

  hp_slot_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .populated_i(populated_i),
    .wr_i       (ctrl_wr),
    .be_i       (wr_be_i),
    .data_i     (wr_data_i),
    .present_i  (sts_q[S_PRES]),
    .ctrl_q_o   (ctrl_q),
    .ctrl_d_o   (ctrl_d),
    .lock_tgl_o (lock_tgl),
    .detach_o   (detach)
  );

  hp_slot_sts_reg u_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .populated_i(populated_i),
    .wr_i       (sts_wr),
    .be_i       (wr_be_i),
    .data_i     (wr_data_i),
    .cmd_i      (ctrl_wr),
    .lock_tgl_i (lock_tgl),
    .detach_i   (detach),
    .insert_i   (card_insert_i),
    .remove_i   (card_remove_i),
    .button_i   (button_i),
    .sts_q_o    (sts_q),
    .sts_d_o    (sts_d),
    .busy_o     (busy)
  );

  hp_slot_notify #(.VEC_W(VEC_W)) u_ntf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctrl_d_i(ctrl_d),
    .sts_d_i (sts_d),
    .msg_en_i(msg_en_i),
    .vec_i   (msg_vec_i),
    .irq_o   (irq_o),
    .msg_o   (msg_req_o),
    .vec_o   (msg_vec_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      detach_q <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      detach_q <= detach;
      busy_q   <= busy;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign status_o   = sts_q;
  assign detach_o   = detach_q;
  assign busy_err_o = busy_q;
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ctrl_wr_i,
  input logic lock_wr_i,
  input logic msg_en_i,
  input logic hp_en_i,
  input logic sts_pdc_i,
  input logic sts_cc_i,
  input logic sts_pres_i,
  input logic sts_lock_i,
  input logic irq_i,
  input logic msg_req_i,
  input logic detach_i
);
  // R3
  msg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_i |=> !msg_req_i);
  // R3
  msg_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_i |-> hp_en_i);
  // R2
  irq_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (!msg_en_i && hp_en_i));
  // R7
  cmd_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> sts_cc_i);
  // R8
  lock_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && lock_wr_i) |=> (sts_lock_i != $past(sts_lock_i)));
  // R9
  detach_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detach_i |-> (!sts_pres_i && sts_pdc_i));
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_wr_i (wr_en_i & ~wr_sel_i),
  .lock_wr_i (wr_be_i[1] & wr_data_i[11]),
  .msg_en_i  (msg_en_i),
  .hp_en_i   (ctrl_o[5]),
  .sts_pdc_i (status_o[3]),
  .sts_cc_i  (status_o[4]),
  .sts_pres_i(status_o[6]),
  .sts_lock_i(status_o[7]),
  .irq_i     (irq_o),
  .msg_req_i (msg_req_o),
  .detach_i  (detach_o)
);

// File: tb/hp_slot_ctrl_test.sv
module hp_slot_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic populated_i = 1'b1;
  logic wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [1:0] wr_be_i = '0;
  logic [15:0] wr_data_i = '0;
  logic card_insert_i = 1'b0, card_remove_i = 1'b0, button_i = 1'b0;
  logic msg_en_i = 1'b0;
  logic [4:0] msg_vec_i = '0;
  logic [15:0] ctrl_o, status_o;
  logic irq_o, msg_req_o, detach_o, busy_err_o;
  logic [4:0] msg_vec_o;

  int total = 0, fails = 0;
  logic [15:0] m_ctrl, m_sts;
  logic m_lvl;

  always #10 clk = ~clk;

  hp_slot_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .populated_i(populated_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_be_i(wr_be_i), .wr_data_i(wr_data_i),
    .card_insert_i(card_insert_i), .card_remove_i(card_remove_i), .button_i(button_i),
    .msg_en_i(msg_en_i), .msg_vec_i(msg_vec_i),
    .ctrl_o(ctrl_o), .status_o(status_o), .irq_o(irq_o), .msg_req_o(msg_req_o),
    .msg_vec_o(msg_vec_o), .detach_o(detach_o), .busy_err_o(busy_err_o)
  );

  task automatic chk(input string name, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", name, got, exp);
    end
  endtask

  task automatic do_reset(input logic pop);
    @(negedge clk);
    rst_ni = 1'b0;
    populated_i = pop;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    m_ctrl = pop ? 16'h01C0 : 16'h07C0;
    m_sts  = pop ? 16'h0040 : 16'h0000;
    m_lvl  = 1'b0;
  endtask

  // one cycle of stimulus, checked against the requirement model
  task automatic step(input string name, input logic we, input logic sel, input logic [1:0] be,
                      input logic [15:0] data, input logic ins, input logic rem, input logic btn);
    logic [15:0] c, s;
    logic cmd, tgl, det, busy, lvl, e_msg, e_irq;
    c = m_ctrl;
    s = m_sts;
    cmd = we & ~sel;
    if (cmd) begin
      if (be[0]) c[7:0]  = data[7:0]  & 8'hF9;
      if (be[1]) c[15:8] = data[15:8] & 8'h07;
    end
    tgl = cmd & be[1] & data[11];
    det = cmd & m_sts[6] & c[10] & (c[9:8] == 2'b11);
    if (we && sel) begin
      if (be[0]) s = s & ~(data & 16'h0019);
    end
    if (cmd) s[4] = 1'b1;
    if (tgl) s[7] = ~m_sts[7];
    busy = ins & m_sts[7];
    if (ins && !m_sts[7]) begin s[6] = 1'b1; s[3] = 1'b1; s[0] = 1'b1; end
    if ((rem && m_sts[6]) || det) begin s[6] = 1'b0; s[3] = 1'b1; end
    if (btn) s[0] = 1'b1;
    lvl = c[5] & (|(s & c & 16'h0019));
    e_msg = msg_en_i & lvl & ~m_lvl;
    e_irq = lvl & ~msg_en_i;

    wr_en_i = we; wr_sel_i = sel; wr_be_i = be; wr_data_i = data;
    card_insert_i = ins; card_remove_i = rem; button_i = btn;
    @(negedge clk);
    chk({name, " ctrl"}, ctrl_o, c);
    chk({name, " status"}, status_o, s);
    chk({name, " irq"}, {15'd0, irq_o}, {15'd0, e_irq});
    chk({name, " msg"}, {15'd0, msg_req_o}, {15'd0, e_msg});
    if (e_msg) chk({name, " vector"}, {11'd0, msg_vec_o}, {11'd0, msg_vec_i});
    chk({name, " detach"}, {15'd0, detach_o}, {15'd0, det});
    chk({name, " busy"}, {15'd0, busy_err_o}, {15'd0, busy});
    wr_en_i = 1'b0; card_insert_i = 1'b0; card_remove_i = 1'b0; button_i = 1'b0;
    m_ctrl = c; m_sts = s; m_lvl = lvl;
  endtask

  initial begin
    #(20 * 200000);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(1'b1);
    chk("R1 ctrl populated", ctrl_o, 16'h01C0);
    chk("R1 status populated", status_o, 16'h0040);
    chk("R1 outputs idle", {12'd0, irq_o, msg_req_o, detach_o, busy_err_o}, 16'h0);

    msg_en_i = 1'b0;
    step("R12 R7 enable low byte", 1, 0, 2'b01, 16'h00F9, 0, 0, 0);
    step("R2 R6 clear cc drops irq", 1, 1, 2'b01, 16'h0010, 0, 0, 0);
    step("R10 button", 0, 0, 2'b00, 16'h0000, 0, 0, 1);
    step("R6 wrong byte enable", 1, 1, 2'b10, 16'h00FF, 0, 0, 0);
    step("R6 presence lock not writable", 1, 1, 2'b11, 16'h00C0, 0, 0, 0);
    step("R6 clear button", 1, 1, 2'b01, 16'h0001, 0, 0, 0);
    step("R8 lock on", 1, 0, 2'b10, 16'h0900, 0, 0, 0);
    step("R11 insert while locked", 0, 0, 2'b00, 16'h0000, 1, 0, 0);
    step("R8 lock off", 1, 0, 2'b10, 16'h0900, 0, 0, 0);
    step("R6 clear cc", 1, 1, 2'b01, 16'h0010, 0, 0, 0);
    step("R10 remove", 0, 0, 2'b00, 16'h0000, 0, 1, 0);
    step("R10 insert", 0, 0, 2'b00, 16'h0000, 1, 0, 0);
    step("R10 insert and remove", 0, 0, 2'b00, 16'h0000, 1, 1, 0);
    step("R10 reinsert", 0, 0, 2'b00, 16'h0000, 1, 0, 0);
    step("R6 clear all", 1, 1, 2'b01, 16'h0019, 0, 0, 0);
    step("R9 detach", 1, 0, 2'b10, 16'h0700, 0, 0, 0);
    step("R9 no detach when empty", 1, 0, 2'b10, 16'h0700, 0, 0, 0);

    msg_en_i = 1'b1;
    msg_vec_i = 5'd19;
    step("R3 clear all", 1, 1, 2'b01, 16'h0019, 0, 0, 0);
    step("R5 masked enable", 1, 0, 2'b01, 16'h0001, 0, 0, 0);
    step("R5 button while masked", 0, 0, 2'b00, 16'h0000, 0, 0, 1);
    step("R5 enable delivers", 1, 0, 2'b01, 16'h0021, 0, 0, 0);
    step("R4 button again", 0, 0, 2'b00, 16'h0000, 0, 0, 1);
    step("R3 clear no message", 1, 1, 2'b01, 16'h0001, 0, 0, 0);
    msg_vec_i = 5'd7;
    step("R3 button rises", 0, 0, 2'b00, 16'h0000, 0, 0, 1);

    for (int i = 0; i < 400; i++) begin
      msg_en_i  = 1'($urandom_range(0, 1));
      msg_vec_i = 5'($urandom);
      step("R2 R3 R6 R7 R8 R9 R10 R11 R12 random",
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'($urandom),
           16'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 7) == 0));
    end

    do_reset(1'b0);
    chk("R1 ctrl empty", ctrl_o, 16'h07C0);
    chk("R1 status empty", status_o, 16'h0000);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule